// File: doc/BRIEF.md
# Serial PROM Word Reader

This block fetches one 16-bit word at a time from a parallel PROM that sits behind an external shift register and an external holding register. The only wires to that external logic are a divided serial clock, a load strobe, one serial output and one serial input. A host places a 21-bit word address on the request bus and pulses a start input. The block then runs a fixed three-window sequence and reports the word on its return-data output, together with a one-cycle done pulse.

Each window is 23 serial-clock periods long. In the first window the block shifts out a frame that holds the address and a trailing enable bit. A load strobe then tells the external logic to move the address into its holding register so that the PROM can drive its data. A second window gives the PROM time to respond. A second strobe makes the external logic capture the PROM word into its shift register. In the third window the block shifts the word in and latches it.

The serial clock is the system clock divided by `2*SCLK_HALF`. The block drives its output while the serial clock is low, and the external side shifts on the rising edge. A busy flag refuses new requests until the word has been returned.

Top module: `prom_ser_reader`

## Requirements
- R1: While busy, `ser_clk` is a square wave with a period of `2*SCLK_HALF` system clocks, and each period begins with the clock low. While idle, `ser_clk` is held at 0.
- R2: The first window carries 23 bit times. Bit time 0 is 0. Bit times 1 to 21 carry address bits 20 down to 0, most significant first. Bit time 22 is the enable bit, which is 1. `ser_out` changes only on the edge where `ser_clk` goes low (or stays low at the start of a period), so every bit is stable at the rising edge of `ser_clk`.
- R3: `ser_ld` goes high for exactly one serial period (`2*SCLK_HALF` system clocks) twice per access. The first pulse comes right after the 23rd rising edge of the serial clock. The second comes after a further 23-period access window, so 47 rising edges precede it. `ser_ld` changes only at the start of a serial period.
- R4: `ser_out` is 0 at every rising edge of `ser_clk` outside the address window, and it is 0 whenever the block is idle.
- R5: In the third window `ser_in` is sampled at each rising edge of `ser_clk`. Bit times 1 to 16 carry data bits 15 down to 0, most significant first. Bit time 0 and bit times 17 to 22 have no effect on the result.
- R6: `rd_done` is a one-cycle pulse. `rd_data` takes the new word and `busy` falls on the same edge that raises `rd_done`. The word is visible `1 + 71*2*SCLK_HALF` system clocks after the edge that accepted the request.
- R7: A `req_valid` seen while `busy` is high is ignored. The access in progress keeps its address, and no further access starts after it completes.
- R8: A synchronous active-low reset returns the block to idle. `busy`, `rd_done`, `ser_ld`, `ser_out` and `ser_clk` go to 0, and `rd_data` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start pulse for one word read |
| req_addr | input | 21 | Word address, sampled with the accepted start |
| busy | output | 1 | An access is in progress; requests are ignored |
| rd_data | output | 16 | Last word returned |
| rd_done | output | 1 | One-cycle pulse when `rd_data` is updated |
| ser_clk | output | 1 | Divided serial clock to the external registers |
| ser_ld | output | 1 | Load strobe to the external registers |
| ser_out | output | 1 | Serial address frame, MSB first |
| ser_in | input | 1 | Serial data from the external shift register |

## Verification
Each result has a fixed arrival time. The word and done pulse arrive `1 + 71*P` system clocks after the accepting edge, where P is the serial period. The two strobes arrive after exactly 23 and 47 rising serial edges, each lasting P system clocks. Every address bit is due at one given rising edge. The bench counts cycles from the accepting edge, sampling on the falling system-clock edge, and expects the done pulse on exactly that count. A model of the external registers acts on `ser_clk` and `ser_ld` edges just as real hardware would. It records the shifted frame, the rising-edge index of each strobe and the strobe widths, and these are compared after the transfer. The model fills the don't-care data bit times with ones, so any sampling slip or miscount shows up in the returned word.

// File: rtl/prom_ser_pkg.sv
// Package: shared types for the serial PROM word reader.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package prom_ser_pkg;

    // Kind of serial period the sequencer will run next.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_STB1 = 3'd2,
        PH_WAIT = 3'd3,
        PH_STB2 = 3'd4,
        PH_DATA = 3'd5,
        PH_FIN  = 3'd6
    } phase_e;

endpackage

// File: rtl/prom_sclk_div.sv
// Module: prom_sclk_div
// Divides the system clock into the serial clock while 'run' is high.
// A serial period is 2*HALF system clocks. tick_fall marks the edge that
// starts a period (clock driven low) and tick_rise the mid-period edge
// (clock driven high). Assumes HALF >= 1. While not running, the
// counter rests at zero and the serial clock stays low.
module prom_sclk_div #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic tick_fall,
    output logic tick_rise
);
    localparam int PER = 2 * HALF;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt;

    // Period markers decoded from the divider count.
    assign tick_fall = run && (cnt == '0);
    assign tick_rise = run && (cnt == CW'(HALF));

    // Divider count: wraps every serial period, parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == CW'(PER - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Serial clock register: low at the start of a period, high mid-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            sclk <= 1'b0;
        else if (tick_rise)
            sclk <= 1'b1;
        else if (tick_fall)
            sclk <= 1'b0;
    end

    // R1
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

    // R1
    sclk_rise_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(tick_rise));

endmodule

// File: rtl/prom_seq.sv
// Module: prom_seq
// Sequencer for one word read: address window, first strobe, access
// window, second strobe, data window, finish. Every window is WIN serial
// periods. The state names the period that starts at the next tick_fall.
// Assumes tick_fall only occurs while busy is high.
module prom_seq
    import prom_ser_pkg::*;
#(
    parameter int WIN = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic tick_fall,
    output logic busy,
    output logic accept,
    output logic shift_out,
    output logic sample_en,
    output logic finish,
    output logic ld
);
    localparam int SW = (WIN > 2) ? $clog2(WIN) : 1;

    phase_e        nxt;
    logic [SW-1:0] slot;
    logic          last_slot;

    // Request acceptance and the per-period control pulses.
    assign accept    = req_valid && !busy;
    assign last_slot = (slot == SW'(WIN - 1));
    assign shift_out = tick_fall && (nxt == PH_ADDR);
    assign finish    = tick_fall && (nxt == PH_FIN);

    // Period sequencer: advances the phase and slot at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            nxt       <= PH_IDLE;
            slot      <= '0;
            ld        <= 1'b0;
            sample_en <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
            nxt  <= PH_ADDR;
            slot <= '0;
        end else if (tick_fall) begin
            case (nxt)
                PH_ADDR: begin
                    ld   <= 1'b0;
                    slot <= last_slot ? '0 : slot + 1'b1;
                    if (last_slot) nxt <= PH_STB1;
                end
                PH_STB1: begin
                    ld  <= 1'b1;
                    nxt <= PH_WAIT;
                end
                PH_WAIT: begin
                    ld   <= 1'b0;
                    slot <= last_slot ? '0 : slot + 1'b1;
                    if (last_slot) nxt <= PH_STB2;
                end
                PH_STB2: begin
                    ld  <= 1'b1;
                    nxt <= PH_DATA;
                end
                PH_DATA: begin
                    ld        <= 1'b0;
                    sample_en <= 1'b1;
                    slot      <= last_slot ? '0 : slot + 1'b1;
                    if (last_slot) nxt <= PH_FIN;
                end
                PH_FIN: begin
                    sample_en <= 1'b0;
                    busy      <= 1'b0;
                    nxt       <= PH_IDLE;
                end
                default: begin
                    ld  <= 1'b0;
                    nxt <= PH_IDLE;
                end
            endcase
        end
    end

    // R3
    ld_on_period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ld) |-> $past(tick_fall));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

    // R6
    finish_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);

    // R3
    ld_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ld);

endmodule

// File: rtl/prom_sreg.sv
// Module: prom_sreg
// Datapath for the reader. It holds the outgoing frame register
// (zero, address, enable bit, padding) and drives the serial output
// register. It also holds the incoming shift register, sampled on
// mid-period ticks, and the return-data register with its done pulse.
// Assumes WIN >= ADDR_W + 2 and WIN >= DATA_W + 1.
module prom_sreg #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int WIN    = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_frame,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              tick_fall,
    input  logic              tick_rise,
    input  logic              shift_out,
    input  logic              sample_en,
    input  logic              finish,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);
    localparam int FRAME_W = ADDR_W + 2;
    localparam int PAD     = WIN - FRAME_W;
    localparam int D_MSB   = WIN - 2;

    logic [WIN-1:0] out_sr;
    logic [WIN-1:0] in_sr;
    logic [WIN-1:0] frame_val;

    // Frame image: leading zero, address MSB first, enable bit, zero pad.
    assign frame_val = WIN'({1'b0, req_addr, 1'b1}) << PAD;

    // Outgoing frame register: parallel load on accept, shift per period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_sr <= '0;
        else if (load_frame)
            out_sr <= frame_val;
        else if (shift_out)
            out_sr <= {out_sr[WIN-2:0], 1'b0};
    end

    // Serial output register: new bit at each period start, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_out <= 1'b0;
        else if (tick_fall)
            ser_out <= shift_out ? out_sr[WIN-1] : 1'b0;
    end

    // Incoming shift register: one sample per rising serial edge in the data window.
    always_ff @(posedge clk) begin
        if (!rst_n || load_frame)
            in_sr <= '0;
        else if (tick_rise && sample_en)
            in_sr <= {in_sr[WIN-2:0], ser_in};
    end

    // Return-data register and done pulse, written at the finish period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= finish;
            if (finish)
                rd_data <= in_sr[D_MSB -: DATA_W];
        end
    end

    // R2
    sdo_on_period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_out) |-> $past(tick_fall));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R6
    data_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> rd_done);

endmodule

// File: rtl/prom_ser_reader.sv
// Module: prom_ser_reader (top)
// Reads one word from a PROM behind external shift and holding registers
// over a serial clock, a load strobe and one wire in each direction.
// The host gives an address with a start pulse. The word comes back in
// rd_data with a one-cycle rd_done. Assumes req_addr is stable on the
// cycle req_valid is accepted.
module prom_ser_reader #(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int WIN       = 23,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic              ser_clk,
    output logic              ser_ld,
    output logic              ser_out,
    input  logic              ser_in
);
    logic tick_fall;
    logic tick_rise;
    logic accept;
    logic shift_out;
    logic sample_en;
    logic finish;

    // Serial clock generation.
    prom_sclk_div #(.HALF(SCLK_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sclk      (ser_clk),
        .tick_fall (tick_fall),
        .tick_rise (tick_rise)
    );

    // Window and strobe sequencing.
    prom_seq #(.WIN(WIN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .tick_fall (tick_fall),
        .busy      (busy),
        .accept    (accept),
        .shift_out (shift_out),
        .sample_en (sample_en),
        .finish    (finish),
        .ld        (ser_ld)
    );

    // Frame out, word in, return data.
    prom_sreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN(WIN)) u_sreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_frame (accept),
        .req_addr   (req_addr),
        .tick_fall  (tick_fall),
        .tick_rise  (tick_rise),
        .shift_out  (shift_out),
        .sample_en  (sample_en),
        .finish     (finish),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .rd_data    (rd_data),
        .rd_done    (rd_done)
    );

    // R4
    idle_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_out);

    // R6
    done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !busy);

    // R3
    ld_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_ld) |-> !ser_clk);

endmodule

// File: tb/prom_ser_reader_bench.sv
`timescale 1ns/1ps
// Directed bench for prom_ser_reader with a model of the external
// shift and holding registers and of the PROM.
module prom_ser_reader_bench;
    localparam int HALF = 2;
    localparam int P    = 2 * HALF;
    localparam int LAT  = 1 + 71 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [20:0] req_addr = '0;
    logic        busy;
    logic [15:0] rd_data;
    logic        rd_done;
    logic        ser_clk;
    logic        ser_ld;
    logic        ser_out;
    logic        ser_in = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // external model state
    logic [22:0] ext_sr = '0;
    logic [22:0] pres = '0;
    logic [22:0] dsr = '0;
    int ld_n = 0;
    int rises = 0;
    int rise_at_ld0 = -1;
    int rise_at_ld1 = -1;
    int bad_out = 0;
    int per_bad = 0;
    int last_rise = 0;
    int ld_run = 0;
    int ld_wbad = 0;
    int ld_pulses = 0;

    prom_ser_reader #(.SCLK_HALF(HALF)) u_prom_ser_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .rd_data(rd_data), .rd_done(rd_done),
        .ser_clk(ser_clk), .ser_ld(ser_ld), .ser_out(ser_out), .ser_in(ser_in)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] prom_word(input logic [20:0] a);
        return a[15:0] ^ {a[20:16], a[20:10]} ^ 16'hA5C3;
    endfunction

    // external model: strobe edges
    always @(posedge ser_ld) begin
        if (ld_n == 0) begin
            pres = ext_sr;
            rise_at_ld0 = rises;
        end else begin
            dsr = {1'b1, (pres[0] ? prom_word(pres[21:1]) : 16'hFFFF), 6'h3F};
            ser_in = dsr[22];
            rise_at_ld1 = rises;
        end
        ld_n = ld_n + 1;
    end

    // external model: rising serial edges shift both registers
    always @(posedge ser_clk) begin
        if (last_rise != 0 && (cyc - last_rise) != P) per_bad = per_bad + 1;
        last_rise = cyc;
        if (rises >= 23 && ser_out) bad_out = bad_out + 1;
        if (!ser_ld) begin
            ext_sr = {ext_sr[21:0], ser_out};
            if (ld_n == 2) begin
                dsr = {dsr[21:0], 1'b1};
                ser_in = dsr[22];
            end
        end
        rises = rises + 1;
    end

    // strobe width monitor
    always @(posedge clk) begin
        if (ser_ld) ld_run = ld_run + 1;
        else if (ld_run != 0) begin
            if (ld_run != P) ld_wbad = ld_wbad + 1;
            ld_pulses = ld_pulses + 1;
            ld_run = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        ld_n = 0; rises = 0; rise_at_ld0 = -1; rise_at_ld1 = -1;
        bad_out = 0; per_bad = 0; last_rise = 0; ld_wbad = 0; ld_pulses = 0;
        ext_sr = '0; pres = '0; dsr = '0; ser_in = 1'b0;
    endtask

    // R8: state right after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 busy", busy, 0);
        chk("R8 rd_done", rd_done, 0);
        chk("R8 rd_data", rd_data, 0);
        chk("R8 ser_ld", ser_ld, 0);
        chk("R8 ser_out", ser_out, 0);
        chk("R8 ser_clk", ser_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1..R7: one full read; 'poke' fires a second request mid-access
    task automatic t_read(input logic [20:0] a, input bit poke);
        int lat;
        model_clear();
        req_addr = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        chk("R7 busy after accept", busy, 1);
        while (!rd_done && lat < 2000) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 100) begin
                req_addr = ~a;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk("R6 done latency", lat, LAT);
        chk("R6 busy low at done", busy, 0);
        chk("R5 word", rd_data, prom_word(a));
        chk("R2 address bits", pres[21:1], a);
        chk("R2 enable bit", pres[0], 1);
        chk("R2 leading zero", pres[22], 0);
        chk("R3 first strobe position", rise_at_ld0, 23);
        chk("R3 second strobe position", rise_at_ld1, 47);
        chk("R3 strobe width errors", ld_wbad, 0);
        chk("R3 strobe count", ld_pulses, 2);
        chk("R4 ser_out outside window", bad_out, 0);
        chk("R1 serial period errors", per_bad, 0);
        @(negedge clk);
        chk("R6 done one cycle", rd_done, 0);
        repeat (3 * P) @(negedge clk);
        chk("R7 no restart busy", busy, 0);
        chk("R1 idle ser_clk low", ser_clk, 0);
        chk("R7 no extra strobe", ld_n, 2);
        chk("R6 data held", rd_data, prom_word(a));
    endtask

    // R8: reset in the middle of an access
    task automatic t_midreset(input logic [20:0] a);
        model_clear();
        req_addr = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (150) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 mid busy", busy, 0);
        chk("R8 mid rd_data", rd_data, 0);
        chk("R8 mid ser_ld", ser_ld, 0);
        chk("R8 mid ser_out", ser_out, 0);
        chk("R8 mid ser_clk", ser_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_read(21'h000000, 1'b0);
        t_read(21'h1FFFFF, 1'b0);
        t_read(21'h155555, 1'b0);
        t_read(21'h0AAAAA, 1'b1);
        chk("R5 nonzero before mid reset", (rd_data != 0), 1);
        t_midreset(21'h123456);
        t_read(21'h123456, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule